// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block chooses a clock source and a gate source for every channel of a bank of counters. The counters are built as three groups. Each group has two counters, and each counter has three channels, so the bank has eighteen channel slots. A host programs the routing with single-byte writes. One register per group sets clock choices, and one register per group sets gate choices. Each write changes the selection of exactly one slot.

From a 40 MHz system clock, a prescaler and a chain of decade counters produce single-cycle enables at 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz. A 20 MHz enable is also produced. Each slot leaves the block as a clock enable and a gate level; no derived clock is generated. An enable bit widens the legal source codes from 0–7 to 0–31. It also unlocks the 20 MHz reference.

Top module: `ctr_src_router`

## Requirements
- R1: After reset, every slot has clock source 0 and gate source 0, and enhanced mode is off. All `gate_out` bits are therefore 1, and `clk_en` only follows the external clock pins.
- R2: A select byte is decoded as follows. Bit 5 picks the counter within the group. Bits 4:3 give the channel. The source code is bits 7:6 (as source bits 4:3) joined with bits 2:0 (as source bits 2:0). Clock registers are at addresses 0x18, 0x19 and 0x1A for groups 0, 1 and 2. Gate registers are at 0x1B, 0x1C and 0x1D for the same groups. The slot number is (group*2 + counter)*3 + channel.
- R3: Address 0x20 holds the enhanced-mode flag in data bit 0. Writing 1 sets the flag and writing 0 clears it.
- R4: A select write whose channel field equals 3 changes no selection.
- R5: While enhanced mode is off, a select write whose source code is above 7 changes no selection. While enhanced mode is on, codes 0–31 are accepted.
- R6: Clock sources 1 to 5 give one-cycle enables. They repeat every 4, 40, 400, 4000 and 40000 system-clock cycles respectively.
- R7: Clock source 11 gives a one-cycle enable every 2 cycles while enhanced mode is on. While enhanced mode is off it gives no enable, even if the code was stored earlier.
- R8: Clock source 0 drives `clk_en` high for the single cycle in which the slot's `ext_clk` pin is high after it was low at the previous clock edge.
- R9: Gate source 0 drives `gate_out` to 1, and gate source 1 passes the slot's `ext_gate` pin. Every other gate code drives 0. Every clock code other than 0–5 and 11 drives no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 6 | Host register address |
| wr_data | input | 8 | Host write byte |
| ext_clk | input | 18 | Dedicated external clock pin per slot |
| ext_gate | input | 18 | Dedicated external gate pin per slot |
| clk_en | output | 18 | Selected clock enable per slot |
| gate_out | output | 18 | Selected gate level per slot |

## Verification
The random phase mixes writes to all six select registers, the mode register and an unused address. It uses random channel fields and random source codes. After each write it applies random pin patterns and compares every slot's gate and edge-derived clock against a reference model. This separates a wrong slot index, a wrong field split and a write that should have been rejected. Directed cases address the last slot, write channel 3, and write codes above 7 with the mode off and then on. These cases show whether rejection depends on the mode flag and not on the code alone. Pulse spacing is measured for each reference. Source 11 is measured with the mode on and again after the mode is turned off, which separates a gated 20 MHz reference from an ungated one.

// File: rtl/ctr_src_router.sv
module ctr_src_router #(
  parameter int         GROUPS   = 3,
  parameter int         CTRS     = 2,
  parameter int         CHANS    = 3,
  parameter int         PRE      = 4,
  parameter logic [5:0] CLK_BASE = 6'h18,
  parameter logic [5:0] ENH_ADDR = 6'h20
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [5:0]                     wr_addr,
  input  logic [7:0]                     wr_data,
  input  logic [GROUPS*CTRS*CHANS-1:0]   ext_clk,
  input  logic [GROUPS*CTRS*CHANS-1:0]   ext_gate,
  output logic [GROUPS*CTRS*CHANS-1:0]   clk_en,
  output logic [GROUPS*CTRS*CHANS-1:0]   gate_out
);
  localparam int         NCH       = GROUPS * CTRS * CHANS;
  localparam int         IW        = $clog2(NCH);
  localparam int         PW        = $clog2(PRE);
  localparam int         NDEC      = 4;
  localparam logic [5:0] GATE_BASE = CLK_BASE + 6'(GROUPS);
  localparam logic [5:0] GATE_END  = GATE_BASE + 6'(GROUPS);

  logic             enh;
  logic [NCH*5-1:0] csel, gsel;
  logic [NCH-1:0]   ext_q;
  logic [PW-1:0]    pre;
  logic [NDEC:0]    tick;
  logic [IW-1:0]    wr_idx;

  wire [4:0] wr_src  = {wr_data[7:6], wr_data[2:0]};
  wire [1:0] wr_ch   = wr_data[4:3];
  wire       is_clk  = (wr_addr >= CLK_BASE) && (wr_addr < GATE_BASE);
  wire       is_gate = (wr_addr >= GATE_BASE) && (wr_addr < GATE_END);
  wire       accept  = wr_en && (int'(wr_ch) < CHANS) && (enh || wr_src < 5'd8);
  wire       clk_wr  = accept && is_clk;
  wire       gate_wr = accept && is_gate;
  wire       t20     = pre[0];

  always_comb begin
    int g;
    g = is_clk ? int'(wr_addr - CLK_BASE) : int'(wr_addr - GATE_BASE);
    wr_idx = IW'((g * CTRS + int'(wr_data[5])) * CHANS + int'(wr_ch));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enh   <= 1'b0;
      csel  <= '0;
      gsel  <= '0;
      ext_q <= '0;
    end else begin
      if (wr_en && wr_addr == ENH_ADDR) enh <= wr_data[0];
      if (clk_wr)  csel[int'(wr_idx)*5 +: 5] <= wr_src;
      if (gate_wr) gsel[int'(wr_idx)*5 +: 5] <= wr_src;
      ext_q <= ext_clk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  pre <= '0;
    else if (pre == PW'(PRE-1))  pre <= '0;
    else                         pre <= pre + 1'b1;
  end

  assign tick[0] = (pre == PW'(PRE-1));

  for (genvar k = 0; k < NDEC; k++) begin : g_dec
    logic [3:0] d;
    always_ff @(posedge clk) begin
      if (!rst_n)       d <= '0;
      else if (tick[k]) d <= (d == 4'd9) ? 4'd0 : d + 4'd1;
    end
    assign tick[k+1] = tick[k] && (d == 4'd9);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire [4:0] cs = csel[i*5 +: 5];
    wire [4:0] gs = gsel[i*5 +: 5];
    logic c;
    always_comb begin
      case (cs)
        5'd0:    c = ext_clk[i] & ~ext_q[i];
        5'd1:    c = tick[0];
        5'd2:    c = tick[1];
        5'd3:    c = tick[2];
        5'd4:    c = tick[3];
        5'd5:    c = tick[4];
        5'd11:   c = enh & t20;
        default: c = 1'b0;
      endcase
    end
    assign clk_en[i]   = c;
    assign gate_out[i] = (gs == 5'd0) | ((gs == 5'd1) & ext_gate[i]);
  end

  AST_BAD_CHAN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ch == 2'd3) |=> ($stable(csel) && $stable(gsel))); // R4
  AST_BAD_SRC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !enh && wr_src > 5'd7) |=> ($stable(csel) && $stable(gsel))); // R5
  AST_CLK_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clk_wr |=> (csel[int'($past(wr_idx))*5 +: 5] == $past(wr_src))); // R2

  for (genvar k = 1; k <= NDEC; k++) begin : g_ast
    AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick[k] |=> !tick[k]); // R6
  end
endmodule

// File: tb/sim_ctr_src_router.sv
module sim_ctr_src_router;
  localparam int N = 18;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [N-1:0] ext_clk = '0, ext_gate = '0, clk_en, gate_out;

  ctr_src_router u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_clk(ext_clk), .ext_gate(ext_gate),
    .clk_en(clk_en), .gate_out(gate_out));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;
  int mc[N], mg[N];
  bit menh;
  logic [N-1:0] prev;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(int w, int ch, int src);
    logic [4:0] s = 5'(src);
    logic [1:0] c = 2'(ch);
    return {s[4:3], w[0], c, s[2:0]};
  endfunction

  function automatic void model_wr(logic [5:0] a, logic [7:0] d);
    int ch = int'(d[4:3]);
    int src = int'({d[7:6], d[2:0]});
    int idx;
    if (a == 6'h20) begin menh = d[0]; return; end
    if (ch == 3 || (!menh && src > 7)) return;
    if (a >= 6'h18 && a <= 6'h1A) begin
      idx = ((int'(a) - 'h18) * 2 + int'(d[5])) * 3 + ch; mc[idx] = src;
    end else if (a >= 6'h1B && a <= 6'h1D) begin
      idx = ((int'(a) - 'h1B) * 2 + int'(d[5])) * 3 + ch; mg[idx] = src;
    end
  endfunction

  function automatic logic [N-1:0] exp_gate(logic [N-1:0] pins);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (mg[i] == 0) || (mg[i] == 1 && pins[i]);
    return r;
  endfunction

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    model_wr(a, d);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ext_clk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin mc[i] = 0; mg[i] = 0; end
    menh = 0; prev = '0;
  endtask

  task automatic step(string req, logic [N-1:0] v, logic [N-1:0] gp);
    logic [N-1:0] m, e;
    @(negedge clk); ext_clk = v; ext_gate = gp; #1;
    m = '0; e = '0;
    for (int i = 0; i < N; i++) begin
      if (mc[i] == 0) begin m[i] = 1'b1; e[i] = v[i] & ~prev[i]; end
      else if (!(mc[i] <= 5 || (mc[i] == 11 && menh))) m[i] = 1'b1;
    end
    chk({req, " clk"}, 32'(clk_en & m), 32'(e));
    chk({req, " gate"}, 32'(gate_out), 32'(exp_gate(gp)));
    prev = v;
  endtask

  task automatic period(string req, int exp);
    int n = 0, m = 0;
    do begin @(negedge clk); n++; end while (!clk_en[0] && n < 90000);
    do begin @(negedge clk); m++; end while (!clk_en[0] && m < 90000);
    chk(req, 32'(m), 32'(exp));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int ppd[5] = '{4, 40, 400, 4000, 40000};
    void'($urandom(32'd4242));
    do_reset();
    #1;
    chk("R1 reset gate", 32'(gate_out), 32'(18'h3FFFF));
    chk("R1 reset clk", 32'(clk_en), 32'h0);
    step("R8 rise", 18'h2AAAA, '0);
    step("R8 held", 18'h2AAAA, '0);
    step("R8 fall/rise", 18'h15555, '0);

    wr(6'h1D, mk(1, 2, 2));
    step("R2 last slot", '0, '0);
    chk("R2 slot17 low", 32'(gate_out), 32'(18'h1FFFF));
    wr(6'h1B, mk(0, 1, 1));
    step("R9 pin gate hi", '0, 18'h00002);
    step("R9 pin gate lo", '0, 18'h00000);
    wr(6'h1B, mk(0, 1, 0));
    wr(6'h1C, mk(1, 3, 2));
    #1 chk("R4 chan3 ignored", 32'(gate_out), 32'(18'h1FFFF));
    wr(6'h1C, mk(0, 0, 9));
    #1 chk("R5 normal >7 ignored", 32'(gate_out), 32'(18'h1FFFF));
    wr(6'h20, 8'h01);
    wr(6'h1C, mk(0, 0, 9));
    #1 chk("R3 R5 enh accepts 9", 32'(gate_out), 32'(18'h1FFBF));
    wr(6'h20, 8'h00);
    wr(6'h1C, mk(0, 0, 0));
    wr(6'h18, mk(0, 0, 17));
    step("R9 reserved clk", 18'h00001, '0);

    for (int it = 0; it < 400; it++) begin
      logic [5:0] a;
      int r = $urandom_range(0, 9);
      a = (r < 6) ? 6'(6'h18 + r) : (r < 8) ? 6'h20 : 6'h1E;
      wr(a, 8'($urandom));
      step("R2 R9 random", 18'($urandom), 18'($urandom));
      step("R8 random", 18'($urandom), 18'($urandom));
    end

    do_reset();
    ext_clk = '0;
    for (int k = 1; k <= 5; k++) begin
      wr(6'h18, mk(0, 0, k));
      period($sformatf("R6 src%0d period", k), ppd[k-1]);
    end
    wr(6'h20, 8'h01);
    wr(6'h18, mk(0, 0, 11));
    period("R7 enh 20M period", 2);
    wr(6'h20, 8'h00);
    begin
      int cnt = 0;
      for (int i = 0; i < 50; i++) begin @(negedge clk); if (clk_en[0]) cnt++; end
      chk("R7 20M off without enh", 32'(cnt), 32'h0);
    end
    do_reset();
    #1 chk("R1 re-reset gate", 32'(gate_out), 32'(18'h3FFFF));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule